// File: doc/BRIEF.md
# Outstanding Request Tracking Table

On a split-transaction bus a request and its data response are separate bus events, and other requests can be issued between them. Every cache controller keeps this table so that it knows which requests are still in flight. When a read or read-exclusive request appears on the request bus, it is written into the slot whose index is the tag that the bus gave the request. Because all controllers see the same tag, every controller uses the same slot. The slot records the block address, the request type, whether this controller is the original requester, and the local snoop result (shared, dirty) found during the request phase. When a response carrying that tag appears, the slot is read out and then released, so the tag can be handed out again.

The processor-side issue logic queries the same table by block address, and every valid slot is compared at once. A hit to a pending read-exclusive, or any hit by a non-read request, holds back the new request. A read that hits a pending read does not issue a request of its own. Instead it marks the slot so that this controller takes the in-flight data when it appears. A controller that takes data it did not request must signal shared, so that other caches load the block in shared state. Write-backs and upgrades get no data response, so they never occupy a slot. The table raises a stall when every slot is in use.

Top module: `otrt_table`

## Requirements
- R1: After reset every slot is empty: `stall` is 0, no lookup hits, and a response to any tag gives `rsp_hit` = 0.
- R2: A bus request with kind read (0) or read-exclusive (1) is stored at the slot whose index equals `breq_tag`. From the next cycle, a lookup of its address reports `lk_hit` = 1, that tag on `lk_tag` and the stored kind on `lk_kind`.
- R3: The lookup is fully associative. Whatever slot an address was stored in, a lookup of that address finds it and returns that slot's index.
- R4: A response with `rsp_valid` = 1 releases the slot named by `rsp_tag` at the clock edge. From the next cycle that address misses and the tag can be stored again.
- R5: `lk_block` is 1 when a lookup hits, unless both the pending kind and the lookup kind are read. A read that hits a pending read-exclusive is blocked.
- R6: When a read hits a pending read, `lk_grab_ok` is 1 and `lk_block` is 0. If `proc_grab` is also 1, the slot's take-data bit is set at the edge, and the later response gives `rsp_take` = 1.
- R7: `breq_own` = 1 marks this controller as the original requester, and its response gives `rsp_take` = 1 with `rsp_assert_shared` = 0. A slot that is taken by a controller that did not request it gives `rsp_assert_shared` = 1.
- R8: `breq_snp_shared` and `breq_snp_dirty` are stored with the request. They are presented on `rsp_snp_shared` and `rsp_snp_dirty` in the cycle that the matching response is on the bus.
- R9: A request of kind upgrade (2) or write-back (3) stores nothing. A later lookup of its address misses.
- R10: If the same tag is released by a response and stored by a new request in one cycle, the release happens first. The slot then holds the new request only.
- R11: `stall` is 1 exactly when all `NUM_TAGS` slots are valid.
- R12: A response to a tag whose slot is empty gives `rsp_hit`, `rsp_take` and `rsp_assert_shared` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| breq_valid | input | 1 | A request is on the request bus this cycle |
| breq_tag | input | TAG_W | Tag the bus assigned to the request |
| breq_kind | input | 2 | Request type: 0 read, 1 read-exclusive, 2 upgrade, 3 write-back |
| breq_addr | input | ADDR_W | Block address of the request |
| breq_own | input | 1 | This controller issued the request |
| breq_snp_shared | input | 1 | Local snoop found the block shared |
| breq_snp_dirty | input | 1 | Local snoop found the block dirty |
| rsp_valid | input | 1 | A data response is on the response bus |
| rsp_tag | input | TAG_W | Tag carried by the response |
| proc_valid | input | 1 | Processor-side lookup request |
| proc_kind | input | 2 | Kind that the processor side wants to issue (same encoding) |
| proc_addr | input | ADDR_W | Block address to look up |
| proc_grab | input | 1 | Register as taker of the pending read's data |
| lk_hit | output | 1 | A valid slot holds the looked-up address |
| lk_tag | output | TAG_W | Index of the slot that hit |
| lk_kind | output | 2 | Pending kind of the slot that hit |
| lk_block | output | 1 | The request must not be issued now |
| lk_grab_ok | output | 1 | The read may take the pending response |
| rsp_hit | output | 1 | The response tag names a valid slot |
| rsp_take | output | 1 | This controller must load the response data |
| rsp_assert_shared | output | 1 | Drive the shared line for this response |
| rsp_snp_shared | output | 1 | Stored snoop shared result for the response |
| rsp_snp_dirty | output | 1 | Stored snoop dirty result for the response |
| stall | output | 1 | All slots are in use |

## Verification
The checker assumes that the bus only hands out a tag whose slot is empty, or whose slot is released in that same cycle. It also assumes that no two valid slots hold the same block address, because the issue logic holds back conflicting requests. The stimulus follows both rules: each tag is reused only after its response, or in the same cycle as its response, and the addresses of pending requests are kept distinct. Responses are sent both to valid tags and, on purpose, to one empty tag.

// File: rtl/otrt_pkg.sv
// Package: request kinds shared by the tracking table, its sub-blocks and checker.
// Assumes the two-bit kind encoding used on the request bus.
package otrt_pkg;

    typedef enum logic [1:0] {
        KIND_RD   = 2'd0,
        KIND_RDX  = 2'd1,
        KIND_UPGR = 2'd2,
        KIND_WB   = 2'd3
    } req_kind_e;

    // True for kinds that are followed by a data response.
    function automatic logic kind_waits_rsp(input logic [1:0] k);
        return (k == KIND_RD) || (k == KIND_RDX);
    endfunction

    // True when both kinds are reads, so they can share one response.
    function automatic logic kinds_shareable(input logic [1:0] pend, input logic [1:0] want);
        return (pend == KIND_RD) && (want == KIND_RD);
    endfunction

endpackage

// File: rtl/otrt_entry.sv
// Module: one slot of the tracking table.
// Holds a pending request's address, kind, ownership, take-data flag and snoop result.
// Assumes a store and a release in the same cycle mean release first, then store.
module otrt_entry #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_en,
    input  logic [ADDR_W-1:0] store_addr,
    input  logic [1:0]        store_kind,
    input  logic              store_own,
    input  logic              store_shared,
    input  logic              store_dirty,
    input  logic              release_en,
    input  logic              take_en,
    output logic              s_valid,
    output logic [ADDR_W-1:0] s_addr,
    output logic [1:0]        s_kind,
    output logic              s_own,
    output logic              s_take,
    output logic              s_shared,
    output logic              s_dirty
);

    // Slot state update: a store wins over a release, which wins over a take mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_valid  <= 1'b0;
            s_addr   <= '0;
            s_kind   <= 2'd0;
            s_own    <= 1'b0;
            s_take   <= 1'b0;
            s_shared <= 1'b0;
            s_dirty  <= 1'b0;
        end else if (store_en) begin
            s_valid  <= 1'b1;
            s_addr   <= store_addr;
            s_kind   <= store_kind;
            s_own    <= store_own;
            s_take   <= 1'b0;
            s_shared <= store_shared;
            s_dirty  <= store_dirty;
        end else if (release_en) begin
            s_valid  <= 1'b0;
            s_take   <= 1'b0;
        end else if (take_en && s_valid) begin
            s_take   <= 1'b1;
        end
    end

endmodule

// File: rtl/otrt_match.sv
// Module: fully associative address compare across all slots.
// Assumes at most one valid slot per address; the lowest index wins otherwise.
module otrt_match #(
    parameter int NUM_TAGS = 8,
    parameter int ADDR_W   = 16,
    localparam int TAG_W   = $clog2(NUM_TAGS)
) (
    input  logic [NUM_TAGS-1:0] ent_valid,
    input  logic [ADDR_W-1:0]   ent_addr [NUM_TAGS],
    input  logic [ADDR_W-1:0]   key_addr,
    output logic                any_hit,
    output logic [TAG_W-1:0]    hit_idx
);

    logic [NUM_TAGS-1:0] eq_vec;

    // One comparator per slot.
    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_cmp
        assign eq_vec[g] = ent_valid[g] && (ent_addr[g] == key_addr);
    end

    // Encode the matching slot index, lowest index first.
    always_comb begin
        hit_idx = '0;
        for (int i = NUM_TAGS - 1; i >= 0; i--) begin
            if (eq_vec[i]) hit_idx = TAG_W'(i);
        end
    end

    assign any_hit = |eq_vec;

endmodule

// File: rtl/otrt_rsp_sel.sv
// Module: reads out the slot named by a response tag.
// Assumes the slot is released by the owner of the slot state at the same edge.
module otrt_rsp_sel #(
    parameter int NUM_TAGS = 8,
    localparam int TAG_W   = $clog2(NUM_TAGS)
) (
    input  logic                rsp_valid,
    input  logic [TAG_W-1:0]    rsp_tag,
    input  logic [NUM_TAGS-1:0] ent_valid,
    input  logic [NUM_TAGS-1:0] ent_own,
    input  logic [NUM_TAGS-1:0] ent_take,
    input  logic [NUM_TAGS-1:0] ent_shared,
    input  logic [NUM_TAGS-1:0] ent_dirty,
    output logic                sel_hit,
    output logic                sel_take,
    output logic                sel_assert_shared,
    output logic                sel_shared,
    output logic                sel_dirty
);

    // Decode the addressed slot's flags, gated by a valid response to a valid slot.
    always_comb begin
        sel_hit           = rsp_valid && ent_valid[rsp_tag];
        sel_take          = sel_hit && (ent_own[rsp_tag] || ent_take[rsp_tag]);
        sel_assert_shared = sel_hit && ent_take[rsp_tag] && !ent_own[rsp_tag];
        sel_shared        = sel_hit && ent_shared[rsp_tag];
        sel_dirty         = sel_hit && ent_dirty[rsp_tag];
    end

endmodule

// File: rtl/otrt_table.sv
// Module: outstanding request tracking table (top).
// Mirrors in-flight bus requests by tag and answers address lookups for issue logic.
// Assumes the bus never reuses a tag that is still pending except in its release cycle.
module otrt_table
    import otrt_pkg::*;
#(
    parameter int NUM_TAGS = 8,
    parameter int ADDR_W   = 16,
    localparam int TAG_W   = $clog2(NUM_TAGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              breq_valid,
    input  logic [TAG_W-1:0]  breq_tag,
    input  logic [1:0]        breq_kind,
    input  logic [ADDR_W-1:0] breq_addr,
    input  logic              breq_own,
    input  logic              breq_snp_shared,
    input  logic              breq_snp_dirty,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic              proc_valid,
    input  logic [1:0]        proc_kind,
    input  logic [ADDR_W-1:0] proc_addr,
    input  logic              proc_grab,
    output logic              lk_hit,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [1:0]        lk_kind,
    output logic              lk_block,
    output logic              lk_grab_ok,
    output logic              rsp_hit,
    output logic              rsp_take,
    output logic              rsp_assert_shared,
    output logic              rsp_snp_shared,
    output logic              rsp_snp_dirty,
    output logic              stall
);

    logic [NUM_TAGS-1:0] ent_valid;
    logic [ADDR_W-1:0]   ent_addr [NUM_TAGS];
    logic [1:0]          ent_kind [NUM_TAGS];
    logic [NUM_TAGS-1:0] ent_own;
    logic [NUM_TAGS-1:0] ent_take;
    logic [NUM_TAGS-1:0] ent_shared;
    logic [NUM_TAGS-1:0] ent_dirty;

    logic                store_req;
    logic                match_hit;
    logic [TAG_W-1:0]    match_idx;
    logic                take_req;

    // Only read and read-exclusive requests wait for a response.
    assign store_req = breq_valid && kind_waits_rsp(breq_kind);

    // One slot per tag, each decoding its own store, release and take strobes.
    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_slot
        otrt_entry #(.ADDR_W(ADDR_W)) u_entry (
            .clk          (clk),
            .rst_n        (rst_n),
            .store_en     (store_req && (breq_tag == TAG_W'(g))),
            .store_addr   (breq_addr),
            .store_kind   (breq_kind),
            .store_own    (breq_own),
            .store_shared (breq_snp_shared),
            .store_dirty  (breq_snp_dirty),
            .release_en   (rsp_valid && (rsp_tag == TAG_W'(g))),
            .take_en      (take_req && (match_idx == TAG_W'(g))),
            .s_valid      (ent_valid[g]),
            .s_addr       (ent_addr[g]),
            .s_kind       (ent_kind[g]),
            .s_own        (ent_own[g]),
            .s_take       (ent_take[g]),
            .s_shared     (ent_shared[g]),
            .s_dirty      (ent_dirty[g])
        );
    end

    otrt_match #(.NUM_TAGS(NUM_TAGS), .ADDR_W(ADDR_W)) u_match (
        .ent_valid (ent_valid),
        .ent_addr  (ent_addr),
        .key_addr  (proc_addr),
        .any_hit   (match_hit),
        .hit_idx   (match_idx)
    );

    otrt_rsp_sel #(.NUM_TAGS(NUM_TAGS)) u_rsp (
        .rsp_valid         (rsp_valid),
        .rsp_tag           (rsp_tag),
        .ent_valid         (ent_valid),
        .ent_own           (ent_own),
        .ent_take          (ent_take),
        .ent_shared        (ent_shared),
        .ent_dirty         (ent_dirty),
        .sel_hit           (rsp_hit),
        .sel_take          (rsp_take),
        .sel_assert_shared (rsp_assert_shared),
        .sel_shared        (rsp_snp_shared),
        .sel_dirty         (rsp_snp_dirty)
    );

    // Lookup result and issue decision for the processor side.
    always_comb begin
        lk_hit     = proc_valid && match_hit;
        lk_tag     = lk_hit ? match_idx : '0;
        lk_kind    = lk_hit ? ent_kind[match_idx] : 2'd0;
        lk_grab_ok = lk_hit && kinds_shareable(ent_kind[match_idx], proc_kind);
        lk_block   = lk_hit && !lk_grab_ok;
    end

    assign take_req = lk_grab_ok && proc_grab;
    assign stall    = &ent_valid;

endmodule

// File: rtl/otrt_table_chk.sv
// Module: assertion checker for the tracking table, bound to every instance.
// Assumes the tag and address discipline described in the brief.
module otrt_table_chk #(
    parameter int NUM_TAGS = 8,
    localparam int TAG_W   = $clog2(NUM_TAGS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                breq_valid,
    input logic [TAG_W-1:0]    breq_tag,
    input logic [1:0]          breq_kind,
    input logic                rsp_valid,
    input logic [TAG_W-1:0]    rsp_tag,
    input logic                lk_block,
    input logic                lk_grab_ok,
    input logic                rsp_hit,
    input logic                rsp_take,
    input logic                rsp_assert_shared,
    input logic                stall,
    input logic [NUM_TAGS-1:0] ent_valid
);

    AST_STORE_AT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (breq_valid && !breq_kind[1]) |=> ent_valid[$past(breq_tag)]);                       // R2
    AST_RELEASE_BY_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !(breq_valid && !breq_kind[1] && breq_tag == rsp_tag))
        |=> !ent_valid[$past(rsp_tag)]);                                                     // R4
    AST_BLOCK_XOR_GRAB: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_block && lk_grab_ok));                                                          // R5
    AST_SHARED_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_assert_shared |-> (rsp_hit && rsp_take));                                        // R7
    AST_NO_SLOT_FOR_NODATA: assert property (@(posedge clk) disable iff (!rst_n)
        (breq_valid && breq_kind[1] && !rsp_valid) |=> (ent_valid == $past(ent_valid)));     // R9
    AST_STALL_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(breq_valid));                                                 // R11
    AST_EMPTY_TAG_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !ent_valid[rsp_tag]) |-> (!rsp_hit && !rsp_take));                     // R12

endmodule

bind otrt_table otrt_table_chk #(.NUM_TAGS(NUM_TAGS)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .breq_valid        (breq_valid),
    .breq_tag          (breq_tag),
    .breq_kind         (breq_kind),
    .rsp_valid         (rsp_valid),
    .rsp_tag           (rsp_tag),
    .lk_block          (lk_block),
    .lk_grab_ok        (lk_grab_ok),
    .rsp_hit           (rsp_hit),
    .rsp_take          (rsp_take),
    .rsp_assert_shared (rsp_assert_shared),
    .stall             (stall),
    .ent_valid         (ent_valid)
);

// File: tb/otrt_table_bench.sv
// Bench: a vector table walked cycle by cycle, then directed reset and full-table tests.
module otrt_table_bench;

    localparam int NUM_TAGS = 8;
    localparam int ADDR_W   = 16;
    localparam int TAG_W    = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              breq_valid;
    logic [TAG_W-1:0]  breq_tag;
    logic [1:0]        breq_kind;
    logic [ADDR_W-1:0] breq_addr;
    logic              breq_own, breq_snp_shared, breq_snp_dirty;
    logic              rsp_valid;
    logic [TAG_W-1:0]  rsp_tag;
    logic              proc_valid;
    logic [1:0]        proc_kind;
    logic [ADDR_W-1:0] proc_addr;
    logic              proc_grab;
    logic              lk_hit, lk_block, lk_grab_ok;
    logic [TAG_W-1:0]  lk_tag;
    logic [1:0]        lk_kind;
    logic              rsp_hit, rsp_take, rsp_assert_shared, rsp_snp_shared, rsp_snp_dirty;
    logic              stall;

    int errors = 0;
    int checks = 0;

    // 8 ns period gives 125 MHz.
    always #4 clk = ~clk;

    otrt_table #(.NUM_TAGS(NUM_TAGS), .ADDR_W(ADDR_W)) u_otrt_table (.*);

    typedef struct packed {
        logic [7:0]  req;
        logic        bv;
        logic [2:0]  bt;
        logic [1:0]  bk;
        logic [15:0] ba;
        logic        bo, bs, bd;
        logic        rv;
        logic [2:0]  rt;
        logic        pv;
        logic [1:0]  pk;
        logic [15:0] pa;
        logic        pg;
        logic        e_hit;
        logic [2:0]  e_tag;
        logic        e_blk, e_grab, e_rhit, e_take, e_ash, e_rsh, e_rdt;
    } vec_t;

    // Fields: req | bus request bv,bt,bk,ba,bo,bs,bd | response rv,rt | lookup pv,pk,pa,pg |
    // expected hit,tag,block,grab_ok,rsp_hit,take,assert_shared,snp_shared,snp_dirty.
    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        // R2: store read at tag 2 (not own); empty table misses
        '{8'd2, 1'b1,3'd2,2'd0,16'h0100,1'b0,1'b0,1'b0, 1'b0,3'd0, 1'b1,2'd0,16'h0100,1'b0, 1'b0,3'd0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0},
        // R6: read hits pending read, grab registered; R8 store rdx tag 5 with snoop bits
        '{8'd6, 1'b1,3'd5,2'd1,16'h0200,1'b0,1'b1,1'b1, 1'b0,3'd0, 1'b1,2'd0,16'h0100,1'b1, 1'b1,3'd2,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0},
        // R5: rdx hits pending read -> block; write-back at tag 6
        '{8'd5, 1'b1,3'd6,2'd3,16'h0300,1'b0,1'b0,1'b0, 1'b0,3'd0, 1'b1,2'd1,16'h0100,1'b0, 1'b1,3'd2,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0},
        // R5: read hits pending rdx -> block; upgrade at tag 7
        '{8'd5, 1'b1,3'd7,2'd2,16'h0400,1'b0,1'b0,1'b0, 1'b0,3'd0, 1'b1,2'd0,16'h0200,1'b0, 1'b1,3'd5,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0},
        // R9: write-back address not stored
        '{8'd9, 1'b0,3'd0,2'd0,16'h0000,1'b0,1'b0,1'b0, 1'b0,3'd0, 1'b1,2'd3,16'h0300,1'b0, 1'b0,3'd0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0},
        // R9: upgrade address not stored
        '{8'd9, 1'b0,3'd0,2'd0,16'h0000,1'b0,1'b0,1'b0, 1'b0,3'd0, 1'b1,2'd2,16'h0400,1'b0, 1'b0,3'd0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0},
        // R7: response tag 2, grabbed by non-owner -> take and assert shared
        '{8'd7, 1'b0,3'd0,2'd0,16'h0000,1'b0,1'b0,1'b0, 1'b1,3'd2, 1'b1,2'd0,16'h0100,1'b0, 1'b1,3'd2,1'b0,1'b1, 1'b1,1'b1,1'b1,1'b0,1'b0},
        // R8: response tag 5 shows stored snoop bits, no take; R4 tag 2 now released
        '{8'd8, 1'b0,3'd0,2'd0,16'h0000,1'b0,1'b0,1'b0, 1'b1,3'd5, 1'b1,2'd0,16'h0100,1'b0, 1'b0,3'd0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b1,1'b1},
        // R4: tag 5 released; store own read at tag 0
        '{8'd4, 1'b1,3'd0,2'd0,16'h0500,1'b1,1'b1,1'b0, 1'b0,3'd0, 1'b1,2'd0,16'h0200,1'b0, 1'b0,3'd0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0},
        // R10: release and store tag 0 together; R7 owner takes without shared
        '{8'd10, 1'b1,3'd0,2'd1,16'h0600,1'b1,1'b0,1'b0, 1'b1,3'd0, 1'b1,2'd0,16'h0500,1'b0, 1'b1,3'd0,1'b0,1'b1, 1'b1,1'b1,1'b0,1'b1,1'b0},
        // R10: tag 0 holds new rdx; R12 response to empty tag 3
        '{8'd12, 1'b0,3'd0,2'd0,16'h0000,1'b0,1'b0,1'b0, 1'b1,3'd3, 1'b1,2'd1,16'h0600,1'b0, 1'b1,3'd0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0},
        // R10: old address gone; response tag 0 from new content
        '{8'd10, 1'b0,3'd0,2'd0,16'h0000,1'b0,1'b0,1'b0, 1'b1,3'd0, 1'b1,2'd0,16'h0500,1'b0, 1'b0,3'd0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0},
        // R4: tag 0 released
        '{8'd4, 1'b0,3'd0,2'd0,16'h0000,1'b0,1'b0,1'b0, 1'b0,3'd0, 1'b1,2'd0,16'h0600,1'b0, 1'b0,3'd0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0}
    };

    // Compare one value, counting the check.
    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic idle_inputs();
        breq_valid = 0; breq_tag = 0; breq_kind = 0; breq_addr = 0;
        breq_own = 0; breq_snp_shared = 0; breq_snp_dirty = 0;
        rsp_valid = 0; rsp_tag = 0;
        proc_valid = 0; proc_kind = 0; proc_addr = 0; proc_grab = 0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: reset state
        proc_valid = 1; proc_addr = 16'h0000; rsp_valid = 1; rsp_tag = 3'd0;
        #2;
        check("R1 stall", stall, 0);
        check("R1 lk_hit", lk_hit, 0);
        check("R1 rsp_hit", rsp_hit, 0);
        @(negedge clk) idle_inputs();

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            breq_valid = VEC[i].bv; breq_tag = VEC[i].bt; breq_kind = VEC[i].bk;
            breq_addr = VEC[i].ba; breq_own = VEC[i].bo;
            breq_snp_shared = VEC[i].bs; breq_snp_dirty = VEC[i].bd;
            rsp_valid = VEC[i].rv; rsp_tag = VEC[i].rt;
            proc_valid = VEC[i].pv; proc_kind = VEC[i].pk; proc_addr = VEC[i].pa;
            proc_grab = VEC[i].pg;
            #2;
            checks++;
            if ({lk_hit, (lk_hit ? lk_tag : 3'd0), lk_block, lk_grab_ok, rsp_hit, rsp_take,
                 rsp_assert_shared, rsp_snp_shared, rsp_snp_dirty} !==
                {VEC[i].e_hit, VEC[i].e_tag, VEC[i].e_blk, VEC[i].e_grab, VEC[i].e_rhit,
                 VEC[i].e_take, VEC[i].e_ash, VEC[i].e_rsh, VEC[i].e_rdt}) begin
                errors++;
                $display("FAIL R%0d vector %0d: got hit=%0b tag=%0d blk=%0b grab=%0b rh=%0b tk=%0b ash=%0b sh=%0b dt=%0b expected hit=%0b tag=%0d blk=%0b grab=%0b rh=%0b tk=%0b ash=%0b sh=%0b dt=%0b",
                         VEC[i].req, i, lk_hit, lk_tag, lk_block, lk_grab_ok, rsp_hit, rsp_take,
                         rsp_assert_shared, rsp_snp_shared, rsp_snp_dirty,
                         VEC[i].e_hit, VEC[i].e_tag, VEC[i].e_blk, VEC[i].e_grab, VEC[i].e_rhit,
                         VEC[i].e_take, VEC[i].e_ash, VEC[i].e_rsh, VEC[i].e_rdt);
            end
            @(negedge clk);
        end
        idle_inputs();

        // R11: fill all slots, stall only after the last store
        for (int t = 0; t < NUM_TAGS; t++) begin
            breq_valid = 1; breq_tag = TAG_W'(t); breq_kind = 2'd0;
            breq_addr = 16'h1000 + 16'(t); breq_own = 1;
            #2;
            check("R11 stall before full", stall, 0);
            @(negedge clk);
        end
        idle_inputs();
        #2;
        check("R11 stall when full", stall, 1);

        // R3: associative lookup returns the slot index and kind
        proc_valid = 1; proc_kind = 2'd0; proc_addr = 16'h1007;
        #1;
        check("R3 hit tag7", lk_hit, 1);
        check("R3 tag7", lk_tag, 7);
        check("R2 kind read", lk_kind, 0);
        proc_kind = 2'd1; proc_addr = 16'h1003;
        #1;
        check("R3 tag3", lk_tag, 3);
        check("R5 rdx over read blocked", lk_block, 1);
        @(negedge clk);
        proc_valid = 0;
        rsp_valid = 1; rsp_tag = 3'd4;
        @(negedge clk) idle_inputs();
        #2;
        check("R4 stall drops after release", stall, 0);
        check("R11 stall low", stall, 0);
        proc_valid = 1; proc_addr = 16'h1004;
        #1;
        check("R4 released addr misses", lk_hit, 0);

        // R1: reset clears a busy table
        @(negedge clk) rst_n = 0;
        @(negedge clk) rst_n = 1;
        proc_valid = 1; proc_addr = 16'h1000; rsp_valid = 1; rsp_tag = 3'd1;
        #2;
        check("R1 lookup after reset", lk_hit, 0);
        check("R1 rsp after reset", rsp_hit, 0);
        check("R12 take on empty tag", rsp_take, 0);
        @(negedge clk) idle_inputs();
        @(negedge clk);
        finish_run();
    end

endmodule